// File: doc/BRIEF.md
# Segment-Based Logical-to-Physical Address Translator

This block is the front end of a DMA engine. Each logical command carries a logical address, a byte count and a tag. The block turns it into physical requests, using a small table of segments that software fills in as tensors are allocated and empties as they are freed. Each engine has its own table, so one logical value can resolve to different physical addresses on different engines. Logical addresses normally start at 0x1_0000_0000 and cover 64 GB per engine. Physical addresses are 51 bits wide: rack in [50:47], sip in [46:43], cube in [42:38], the HBM-window select in bit 37 (set to 1), and the window offset in [36:0].

Every segment has its own mode. An aggregated segment sends an access through as one request to a single combined target. A fan-out segment splits an access into CH equal per-channel requests. CH is the pseudo-channel count divided by the engines per cube, for example 8, 4 or 16. Each channel has its own physical base and destination ID. The channel parameters are written through a separate plain write port before the segment is installed.

Requests leave on a valid/ready stream. While `req_ready` is low, the request held on the output does not change. A request transfers on any rising edge where `req_valid` and `req_ready` are both high. The command port is also valid/ready. `cmd_ready` is high only while no request is outstanding. The install, channel-write and miss pins are plain single-cycle controls and pulses.

Top module: `seg_xlate`

## Requirements
- R1: After reset no entry is valid, `cmd_ready` is 1 and `req_valid`, `miss_valid` and `inst_err` are 0. An accepted install (`inst_op`=0) sets the entry's valid bit and leaves `inst_err` at 0.
- R2: Entry e matches a logical address `la` when it is valid, base <= la and la < base+size. The offset is la-base. If several entries match, the lowest index is used.
- R3: For a hit on an aggregated entry (`inst_mode`=0), exactly one request is issued. Its fields are: PA = aggregated base + offset, length = full byte count, destination = aggregated ID, `req_last`=1.
- R4: For a hit on a fan-out entry (`inst_mode`=1), CH requests are issued in ascending channel order c = 0..CH-1. Each has PA = channel c base + (offset mod (size/CH)), length = floor(byte count / CH) and destination = channel c ID. Only the final request has `req_last`=1.
- R5: A command that matches no valid entry produces no request. The cycle after it is accepted, `miss_valid` pulses for one cycle with `miss_tag` equal to the command's tag.
- R6: An install whose range overlaps a valid entry at a different index is rejected. `inst_err` pulses for one cycle in the cycle after the install, and the table is left unchanged.
- R7: An install is also rejected, with the same `inst_err` pulse, if its size is zero, or if it is a fan-out install whose size is not a power of two or is smaller than CH.
- R8: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_pa`, `req_len`, `req_dst`, `req_tag` and `req_last` stay unchanged.
- R9: `cmd_ready` is 0 from the cycle after a command with a hit is accepted until the cycle after its last request is accepted.
- R10: A remove (`inst_op`=1) clears the entry's valid bit, so its addresses then miss. Other entries keep translating.
- R11: Every request carries the tag of the command that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_valid | input | 1 | Table operation strobe |
| inst_op | input | 1 | 0 install, 1 remove |
| inst_idx | input | $clog2(ENTRIES) | Entry index |
| inst_base | input | LAW | Segment logical base |
| inst_size | input | LAW | Segment size in bytes |
| inst_mode | input | 1 | 0 aggregated, 1 fan-out |
| inst_agg_pa | input | PAW | Aggregated physical base |
| inst_agg_id | input | IDW | Aggregated destination ID |
| inst_err | output | 1 | One-cycle pulse: install rejected |
| chw_valid | input | 1 | Channel parameter write strobe |
| chw_idx | input | $clog2(ENTRIES) | Entry index for channel write |
| chw_ch | input | $clog2(CH) | Channel number |
| chw_pa | input | PAW | Channel physical base |
| chw_id | input | IDW | Channel destination ID |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command ready |
| cmd_la | input | LAW | Command logical address |
| cmd_len | input | LENW | Command byte count |
| cmd_tag | input | TAGW | Command tag |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request ready |
| req_pa | output | PAW | Request physical address |
| req_len | output | LENW | Request byte count |
| req_dst | output | IDW | Request destination ID |
| req_tag | output | TAGW | Request tag |
| req_last | output | 1 | Final request of a command |
| miss_valid | output | 1 | One-cycle miss pulse |
| miss_tag | output | TAGW | Tag of the missed command |

## Verification
The bench builds the block with ENTRIES=4 and CH=4. With four channels, a fan-out segment of 0x800 bytes gives a 0x200-byte channel size. Offsets above that size then show the modulo wrap, and a byte count of 1030 shows the floor division. Four entries leave room for an aggregated segment, a fan-out segment and a third slot for the overlap, bad-shape and coexistence installs, while still being able to remove one of them.

// File: rtl/segx_pkg.sv
package segx_pkg;
  typedef enum logic {MODE_AGG = 1'b0, MODE_FAN = 1'b1} seg_mode_e;
  typedef enum logic {OP_INSTALL = 1'b0, OP_REMOVE = 1'b1} inst_op_e;
endpackage

// File: rtl/segx_table.sv
module segx_table #(
  parameter int ENTRIES = 8,
  parameter int CH      = 8,
  parameter int LAW     = 40,
  parameter int PAW     = 51,
  parameter int IDW     = 8,
  localparam int IXW    = $clog2(ENTRIES),
  localparam int CHW    = $clog2(CH)
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   inst_valid,
  input  logic                                   inst_op,
  input  logic [IXW-1:0]                         inst_idx,
  input  logic [LAW-1:0]                         inst_base,
  input  logic [LAW-1:0]                         inst_size,
  input  logic                                   inst_mode,
  input  logic [PAW-1:0]                         inst_agg_pa,
  input  logic [IDW-1:0]                         inst_agg_id,
  input  logic                                   chw_valid,
  input  logic [IXW-1:0]                         chw_idx,
  input  logic [CHW-1:0]                         chw_ch,
  input  logic [PAW-1:0]                         chw_pa,
  input  logic [IDW-1:0]                         chw_id,
  output logic [ENTRIES-1:0]                     vld,
  output logic [ENTRIES-1:0][LAW-1:0]            base,
  output logic [ENTRIES-1:0][LAW-1:0]            size,
  output logic [ENTRIES-1:0]                     mode,
  output logic [ENTRIES-1:0][PAW-1:0]            agg_pa,
  output logic [ENTRIES-1:0][IDW-1:0]            agg_id,
  output logic [ENTRIES-1:0][CH-1:0][PAW-1:0]    ch_pa,
  output logic [ENTRIES-1:0][CH-1:0][IDW-1:0]    ch_id,
  output logic                                   inst_err
);
  logic [ENTRIES-1:0] clash;
  logic               bad_shape, is_remove, do_write, reject;

  // Range intersection against every other live entry
  for (genvar e = 0; e < ENTRIES; e++) begin : g_clash
    assign clash[e] = vld[e] && (IXW'(e) != inst_idx) &&
                      ({1'b0, inst_base} < {1'b0, base[e]} + {1'b0, size[e]}) &&
                      ({1'b0, base[e]} < {1'b0, inst_base} + {1'b0, inst_size});
  end

  always_comb begin
    is_remove = (inst_op == segx_pkg::OP_REMOVE);
    bad_shape = (inst_size == '0) ||
                ((inst_mode == segx_pkg::MODE_FAN) &&
                 (((inst_size & (inst_size - 1'b1)) != '0) || (inst_size < LAW'(CH))));
    reject    = (|clash) || bad_shape;
    do_write  = inst_valid && !is_remove && !reject;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld      <= '0;
      inst_err <= 1'b0;
    end else begin
      inst_err <= inst_valid && !is_remove && reject;
      if (inst_valid && is_remove) vld[inst_idx] <= 1'b0;
      else if (do_write)           vld[inst_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_write) begin
      base[inst_idx]   <= inst_base;
      size[inst_idx]   <= inst_size;
      mode[inst_idx]   <= inst_mode;
      agg_pa[inst_idx] <= inst_agg_pa;
      agg_id[inst_idx] <= inst_agg_id;
    end
    if (chw_valid) begin
      ch_pa[chw_idx][chw_ch] <= chw_pa;
      ch_id[chw_idx][chw_ch] <= chw_id;
    end
  end
endmodule

// File: rtl/segx_match.sv
module segx_match #(
  parameter int ENTRIES = 8,
  parameter int LAW     = 40,
  localparam int IXW    = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]          vld,
  input  logic [ENTRIES-1:0][LAW-1:0] base,
  input  logic [ENTRIES-1:0][LAW-1:0] size,
  input  logic [LAW-1:0]              la,
  output logic                        hit,
  output logic [IXW-1:0]              hit_idx,
  output logic [LAW-1:0]              hit_off
);
  logic [ENTRIES-1:0] hitv;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hitv[e] = vld[e] && (la >= base[e]) &&
                     ({1'b0, la} < {1'b0, base[e]} + {1'b0, size[e]});
  end

  always_comb begin
    hit_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (hitv[e]) hit_idx = IXW'(e);
    end
    hit     = |hitv;
    hit_off = la - base[hit_idx];
  end
endmodule

// File: rtl/segx_issue.sv
module segx_issue #(
  parameter int ENTRIES = 8,
  parameter int CH      = 8,
  parameter int LAW     = 40,
  parameter int PAW     = 51,
  parameter int IDW     = 8,
  parameter int LENW    = 24,
  parameter int TAGW    = 4,
  localparam int IXW    = $clog2(ENTRIES),
  localparam int CHW    = $clog2(CH)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cmd_valid,
  output logic                                cmd_ready,
  input  logic [LENW-1:0]                     cmd_len,
  input  logic [TAGW-1:0]                     cmd_tag,
  input  logic                                hit,
  input  logic [IXW-1:0]                      hit_idx,
  input  logic [LAW-1:0]                      hit_off,
  input  logic [ENTRIES-1:0][LAW-1:0]         size,
  input  logic [ENTRIES-1:0]                  mode,
  input  logic [ENTRIES-1:0][PAW-1:0]         agg_pa,
  input  logic [ENTRIES-1:0][IDW-1:0]         agg_id,
  input  logic [ENTRIES-1:0][CH-1:0][PAW-1:0] ch_pa,
  input  logic [ENTRIES-1:0][CH-1:0][IDW-1:0] ch_id,
  output logic                                req_valid,
  input  logic                                req_ready,
  output logic [PAW-1:0]                      req_pa,
  output logic [LENW-1:0]                     req_len,
  output logic [IDW-1:0]                      req_dst,
  output logic [TAGW-1:0]                     req_tag,
  output logic                                req_last,
  output logic                                miss_valid,
  output logic [TAGW-1:0]                     miss_tag
);
  logic [IXW-1:0]  cur_idx, sel_idx;
  logic [LAW-1:0]  cur_off, sel_off, ch_size, ch_mod;
  logic [LENW-1:0] cur_len, sel_len, nx_len;
  logic [CHW-1:0]  cur_ch, sel_ch;
  logic [PAW-1:0]  nx_pa;
  logic [IDW-1:0]  nx_dst;
  logic            accept, advance, load, fan, nx_last;

  assign cmd_ready = !req_valid;

  always_comb begin
    accept  = cmd_valid && cmd_ready;
    advance = req_valid && req_ready && !req_last;
    load    = (accept && hit) || advance;
    sel_idx = accept ? hit_idx : cur_idx;
    sel_off = accept ? hit_off : cur_off;
    sel_len = accept ? cmd_len : cur_len;
    sel_ch  = accept ? '0 : cur_ch + 1'b1;
    fan     = (mode[sel_idx] == segx_pkg::MODE_FAN);
    ch_size = size[sel_idx] >> CHW;
    ch_mod  = sel_off & (ch_size - 1'b1);
    nx_pa   = fan ? ch_pa[sel_idx][sel_ch] + PAW'(ch_mod) : agg_pa[sel_idx] + PAW'(sel_off);
    nx_len  = fan ? (sel_len >> CHW) : sel_len;
    nx_dst  = fan ? ch_id[sel_idx][sel_ch] : agg_id[sel_idx];
    nx_last = !fan || (sel_ch == CHW'(CH - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      miss_valid <= 1'b0;
    end else begin
      miss_valid <= accept && !hit;
      if (accept && hit)                      req_valid <= 1'b1;
      else if (req_valid && req_ready && req_last) req_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      req_pa   <= nx_pa;
      req_len  <= nx_len;
      req_dst  <= nx_dst;
      req_last <= nx_last;
      cur_idx  <= sel_idx;
      cur_off  <= sel_off;
      cur_len  <= sel_len;
      cur_ch   <= sel_ch;
    end
    if (accept && hit)  req_tag  <= cmd_tag;
    if (accept && !hit) miss_tag <= cmd_tag;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int ENTRIES = 8,
  parameter int CH      = 8,
  parameter int LAW     = 40,
  parameter int PAW     = 51,
  parameter int IDW     = 8,
  parameter int LENW    = 24,
  parameter int TAGW    = 4,
  localparam int IXW    = $clog2(ENTRIES),
  localparam int CHW    = $clog2(CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inst_valid,
  input  logic            inst_op,
  input  logic [IXW-1:0]  inst_idx,
  input  logic [LAW-1:0]  inst_base,
  input  logic [LAW-1:0]  inst_size,
  input  logic            inst_mode,
  input  logic [PAW-1:0]  inst_agg_pa,
  input  logic [IDW-1:0]  inst_agg_id,
  output logic            inst_err,
  input  logic            chw_valid,
  input  logic [IXW-1:0]  chw_idx,
  input  logic [CHW-1:0]  chw_ch,
  input  logic [PAW-1:0]  chw_pa,
  input  logic [IDW-1:0]  chw_id,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [LAW-1:0]  cmd_la,
  input  logic [LENW-1:0] cmd_len,
  input  logic [TAGW-1:0] cmd_tag,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [PAW-1:0]  req_pa,
  output logic [LENW-1:0] req_len,
  output logic [IDW-1:0]  req_dst,
  output logic [TAGW-1:0] req_tag,
  output logic            req_last,
  output logic            miss_valid,
  output logic [TAGW-1:0] miss_tag
);
  logic [ENTRIES-1:0]                  t_vld, t_mode;
  logic [ENTRIES-1:0][LAW-1:0]         t_base, t_size;
  logic [ENTRIES-1:0][PAW-1:0]         t_agg_pa;
  logic [ENTRIES-1:0][IDW-1:0]         t_agg_id;
  logic [ENTRIES-1:0][CH-1:0][PAW-1:0] t_ch_pa;
  logic [ENTRIES-1:0][CH-1:0][IDW-1:0] t_ch_id;
  logic                                m_hit;
  logic [IXW-1:0]                      m_idx;
  logic [LAW-1:0]                      m_off;

  segx_table #(.ENTRIES(ENTRIES), .CH(CH), .LAW(LAW), .PAW(PAW), .IDW(IDW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .inst_valid(inst_valid), .inst_op(inst_op), .inst_idx(inst_idx),
    .inst_base(inst_base), .inst_size(inst_size), .inst_mode(inst_mode),
    .inst_agg_pa(inst_agg_pa), .inst_agg_id(inst_agg_id),
    .chw_valid(chw_valid), .chw_idx(chw_idx), .chw_ch(chw_ch),
    .chw_pa(chw_pa), .chw_id(chw_id),
    .vld(t_vld), .base(t_base), .size(t_size), .mode(t_mode),
    .agg_pa(t_agg_pa), .agg_id(t_agg_id), .ch_pa(t_ch_pa), .ch_id(t_ch_id),
    .inst_err(inst_err)
  );

  segx_match #(.ENTRIES(ENTRIES), .LAW(LAW)) u_match (
    .vld(t_vld), .base(t_base), .size(t_size), .la(cmd_la),
    .hit(m_hit), .hit_idx(m_idx), .hit_off(m_off)
  );

  segx_issue #(.ENTRIES(ENTRIES), .CH(CH), .LAW(LAW), .PAW(PAW), .IDW(IDW),
               .LENW(LENW), .TAGW(TAGW)) u_issue (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_len(cmd_len), .cmd_tag(cmd_tag),
    .hit(m_hit), .hit_idx(m_idx), .hit_off(m_off),
    .size(t_size), .mode(t_mode), .agg_pa(t_agg_pa), .agg_id(t_agg_id),
    .ch_pa(t_ch_pa), .ch_id(t_ch_id),
    .req_valid(req_valid), .req_ready(req_ready), .req_pa(req_pa), .req_len(req_len),
    .req_dst(req_dst), .req_tag(req_tag), .req_last(req_last),
    .miss_valid(miss_valid), .miss_tag(miss_tag)
  );
endmodule

// File: rtl/segx_chk.sv
module segx_chk #(
  parameter int PAW  = 51,
  parameter int LENW = 24,
  parameter int IDW  = 8,
  parameter int TAGW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            inst_valid,
  input logic            inst_err,
  input logic            cmd_ready,
  input logic            req_valid,
  input logic            req_ready,
  input logic [PAW-1:0]  req_pa,
  input logic [LENW-1:0] req_len,
  input logic [IDW-1:0]  req_dst,
  input logic [TAGW-1:0] req_tag,
  input logic            req_last,
  input logic            miss_valid
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable({req_pa, req_len, req_dst, req_tag, req_last}))); // R8

  AST_BUSY_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !cmd_ready); // R9

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_last) |=> !req_valid); // R9

  AST_MISS_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> !req_valid); // R5

  AST_ERR_AFTER_INSTALL: assert property (@(posedge clk) disable iff (!rst_n)
    inst_err |-> $past(inst_valid)); // R6
endmodule

bind seg_xlate segx_chk #(.PAW(PAW), .LENW(LENW), .IDW(IDW), .TAGW(TAGW)) u_chk (
  .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .inst_err(inst_err),
  .cmd_ready(cmd_ready), .req_valid(req_valid), .req_ready(req_ready),
  .req_pa(req_pa), .req_len(req_len), .req_dst(req_dst), .req_tag(req_tag),
  .req_last(req_last), .miss_valid(miss_valid)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  localparam int ENTRIES = 4;
  localparam int CH      = 4;
  localparam int LAW     = 40;
  localparam int PAW     = 51;
  localparam int IDW     = 8;
  localparam int LENW    = 24;
  localparam int TAGW    = 4;
  localparam int IXW     = $clog2(ENTRIES);
  localparam int CHW     = $clog2(CH);

  logic clk = 0, rst_n = 0;
  logic inst_valid = 0, inst_op = 0, inst_mode = 0, inst_err;
  logic [IXW-1:0] inst_idx = '0, chw_idx = '0;
  logic [LAW-1:0] inst_base = '0, inst_size = '0, cmd_la = '0;
  logic [PAW-1:0] inst_agg_pa = '0, chw_pa = '0, req_pa;
  logic [IDW-1:0] inst_agg_id = '0, chw_id = '0, req_dst;
  logic chw_valid = 0;
  logic [CHW-1:0] chw_ch = '0;
  logic cmd_valid = 0, cmd_ready, req_valid, req_ready = 0, req_last, miss_valid;
  logic [LENW-1:0] cmd_len = '0, req_len;
  logic [TAGW-1:0] cmd_tag = '0, req_tag, miss_tag;

  int nchk = 0, nerr = 0;
  bit done = 0;

  logic [PAW-1:0]  exp_pa  [0:15];
  logic [LENW-1:0] exp_len [0:15];
  logic [IDW-1:0]  exp_dst [0:15];

  localparam logic [LAW-1:0] S0B = 40'h1_0000_0000;
  localparam logic [LAW-1:0] S1B = 40'h1_0000_1000;

  seg_xlate #(.ENTRIES(ENTRIES), .CH(CH), .LAW(LAW), .PAW(PAW), .IDW(IDW),
              .LENW(LENW), .TAGW(TAGW)) u_dut (.*);

  always #2 clk = ~clk;

  function automatic logic [PAW-1:0] mkpa(input int rack, sip, cube, input logic [36:0] off);
    return {rack[3:0], sip[3:0], cube[4:0], 1'b1, off};
  endfunction

  function automatic logic [PAW-1:0] aggpa0();
    return mkpa(1, 2, 3, 37'h10_0000);
  endfunction

  function automatic logic [PAW-1:0] chpa(input int c);
    return mkpa(1, 2, 4 + c, 37'(c) * 37'h100_0000);
  endfunction

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic install(input int idx, input logic [LAW-1:0] b, input logic [LAW-1:0] s,
                         input logic m, input logic [PAW-1:0] ap, input logic [IDW-1:0] ai,
                         input logic exp_err, input string rq);
    @(negedge clk);
    inst_valid = 1; inst_op = 0; inst_idx = IXW'(idx); inst_base = b; inst_size = s;
    inst_mode = m; inst_agg_pa = ap; inst_agg_id = ai;
    @(negedge clk);
    inst_valid = 0;
    chk(rq, "inst_err", 64'(inst_err), 64'(exp_err));
  endtask

  task automatic remove(input int idx);
    @(negedge clk);
    inst_valid = 1; inst_op = 1; inst_idx = IXW'(idx);
    @(negedge clk);
    inst_valid = 0; inst_op = 0;
    chk("R10", "inst_err on remove", 64'(inst_err), 64'd0);
  endtask

  task automatic chwrite(input int idx, input int c, input logic [PAW-1:0] pa, input logic [IDW-1:0] id);
    @(negedge clk);
    chw_valid = 1; chw_idx = IXW'(idx); chw_ch = CHW'(c); chw_pa = pa; chw_id = id;
    @(negedge clk);
    chw_valid = 0;
  endtask

  // Issue one command; returns at the negedge after acceptance
  task automatic send(input logic [LAW-1:0] la, input logic [LENW-1:0] len, input logic [TAGW-1:0] tag);
    @(negedge clk);
    cmd_valid = 1; cmd_la = la; cmd_len = len; cmd_tag = tag;
    @(posedge clk);
    #1 cmd_valid = 0;
    @(negedge clk);
  endtask

  task automatic check_req(input string rq, input int k, input int n, input logic [TAGW-1:0] tag);
    chk("R9", "cmd_ready while busy", 64'(cmd_ready), 64'd0);
    chk(rq, $sformatf("req_valid[%0d]", k), 64'(req_valid), 64'd1);
    chk(rq, $sformatf("req_pa[%0d]", k), 64'(req_pa), 64'(exp_pa[k]));
    chk(rq, $sformatf("req_len[%0d]", k), 64'(req_len), 64'(exp_len[k]));
    chk(rq, $sformatf("req_dst[%0d]", k), 64'(req_dst), 64'(exp_dst[k]));
    chk(rq, $sformatf("req_last[%0d]", k), 64'(req_last), 64'(k == n - 1));
    chk("R11", $sformatf("req_tag[%0d]", k), 64'(req_tag), 64'(tag));
  endtask

  task automatic collect(input string rq, input int n, input logic [TAGW-1:0] tag, input bit stall);
    for (int k = 0; k < n; k++) begin
      if (stall) begin
        req_ready = 0;
        check_req(rq, k, n, tag);
        @(negedge clk);
        check_req("R8", k, n, tag);
      end else begin
        check_req(rq, k, n, tag);
      end
      req_ready = 1;
      @(negedge clk);
    end
    req_ready = 0;
    chk(rq, "req_valid after last", 64'(req_valid), 64'd0);
    chk("R9", "cmd_ready after last", 64'(cmd_ready), 64'd1);
  endtask

  task automatic expect_miss(input string rq, input logic [TAGW-1:0] tag);
    chk(rq, "miss_valid", 64'(miss_valid), 64'd1);
    chk(rq, "miss_tag", 64'(miss_tag), 64'(tag));
    chk(rq, "req_valid on miss", 64'(req_valid), 64'd0);
    @(negedge clk);
    chk(rq, "miss pulse width", 64'(miss_valid), 64'd0);
    chk(rq, "no req after miss", 64'(req_valid), 64'd0);
  endtask

  task automatic set_fan(input logic [LAW-1:0] off, input logic [LENW-1:0] len);
    for (int c = 0; c < CH; c++) begin
      exp_pa[c]  = chpa(c) + PAW'(off & 40'h1FF);
      exp_len[c] = len / LENW'(CH);
      exp_dst[c] = IDW'(8'h10 + c);
    end
  endtask

  task automatic set_agg(input logic [PAW-1:0] pbase, input logic [LAW-1:0] off,
                         input logic [LENW-1:0] len, input logic [IDW-1:0] id);
    exp_pa[0] = pbase + PAW'(off); exp_len[0] = len; exp_dst[0] = id;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "cmd_ready reset", 64'(cmd_ready), 64'd1);
    chk("R1", "req_valid reset", 64'(req_valid), 64'd0);
    chk("R1", "miss_valid reset", 64'(miss_valid), 64'd0);
    chk("R1", "inst_err reset", 64'(inst_err), 64'd0);
    send(S0B, 24'd64, 4'd2);
    expect_miss("R1", 4'd2);
  endtask

  task automatic t_setup();
    install(0, S0B, 40'h1000, 1'b0, aggpa0(), 8'h40, 1'b0, "R1");
    for (int c = 0; c < CH; c++) chwrite(1, c, chpa(c), IDW'(8'h10 + c));
    install(1, S1B, 40'h800, 1'b1, '0, 8'h00, 1'b0, "R1");
  endtask

  task automatic t_agg();
    send(S0B + 40'h10, 24'd256, 4'd3);
    set_agg(aggpa0(), 40'h10, 24'd256, 8'h40);
    collect("R3", 1, 4'd3, 1'b0);
  endtask

  task automatic t_fan();
    send(S1B + 40'h234, 24'd1024, 4'd5);
    set_fan(40'h234, 24'd1024);
    collect("R4", CH, 4'd5, 1'b0);
    send(S1B + 40'h3F0, 24'd1030, 4'd6);
    set_fan(40'h3F0, 24'd1030);
    collect("R4", CH, 4'd6, 1'b1);
  endtask

  task automatic t_bounds();
    send(S0B + 40'hFFF, 24'd16, 4'd1);
    set_agg(aggpa0(), 40'hFFF, 24'd16, 8'h40);
    collect("R2", 1, 4'd1, 1'b0);
    send(S1B, 24'd64, 4'd4);
    set_fan(40'h0, 24'd64);
    collect("R2", CH, 4'd4, 1'b0);
    send(S1B + 40'h800, 24'd64, 4'd7);
    expect_miss("R5", 4'd7);
    send(40'hFFFF_FFFF, 24'd64, 4'd8);
    expect_miss("R2", 4'd8);
  endtask

  task automatic t_overlap();
    install(2, S0B + 40'h800, 40'h1000, 1'b0, mkpa(0, 0, 9, 37'h0), 8'h55, 1'b1, "R6");
    send(S0B + 40'h900, 24'd32, 4'd10);
    set_agg(aggpa0(), 40'h900, 24'd32, 8'h40);
    collect("R6", 1, 4'd10, 1'b0);
  endtask

  task automatic t_shape();
    install(2, 40'h2_0000_0000, 40'h600, 1'b1, '0, 8'h00, 1'b1, "R7");
    install(2, 40'h2_0000_0000, 40'h2, 1'b1, '0, 8'h00, 1'b1, "R7");
    install(2, 40'h2_0000_0000, 40'h0, 1'b0, '0, 8'h00, 1'b1, "R7");
    send(40'h2_0000_0000, 24'd8, 4'd11);
    expect_miss("R7", 4'd11);
    install(2, 40'h2_0000_0000, 40'h100, 1'b0, mkpa(0, 0, 1, 37'h200), 8'h41, 1'b0, "R7");
    send(40'h2_0000_0080, 24'd8, 4'd12);
    set_agg(mkpa(0, 0, 1, 37'h200), 40'h80, 24'd8, 8'h41);
    collect("R10", 1, 4'd12, 1'b0);
  endtask

  task automatic t_remove();
    remove(0);
    send(S0B + 40'h10, 24'd64, 4'd9);
    expect_miss("R10", 4'd9);
    send(S1B + 40'h10, 24'd128, 4'd13);
    set_fan(40'h10, 24'd128);
    collect("R10", CH, 4'd13, 1'b0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_setup();
    t_agg();
    t_fan();
    t_bounds();
    t_overlap();
    t_shape();
    t_remove();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL R9 watchdog actual=hung expected=complete");
      summary();
      $finish;
    end
  end
endmodule